// File: doc/BRIEF.md
# Audio Stream DMA Channel Register Block

This block holds the control and status registers for one direction of an audio stream DMA engine. Software reaches it through a simple register port: a write strobe with an address and data, and a read path that returns data in the same cycle. Through this port software sets a 64-bit ring-buffer base address, the ring geometry (the bytes in one period and the number of periods), the bytes per channel per period, the sample-width code and the active channel count. The base address is driven out of the block to the transfer engine.

A beat interface stands in for the memory transfers. The block is ready for a beat only while DMA is enabled and no soft reset is running. Each accepted beat advances a byte transfer count by a fixed beat size. The count returns to zero when it reaches the end of the ring. At every period boundary the block raises a sticky period-complete flag, which software clears by writing a one to it. The interrupt output is that flag gated by its enable bit. A self-clearing soft reset returns the running state to idle and keeps the configuration.

Top module: `adma_chan_regs`

## Requirements
- R1: After reset every register reads zero, `irq` is 0, `beat_ready` is 0 and `buf_addr` is zero.
- R2: Software can read back what it wrote to address offset 0x1C (period count in bits 31:16, period bytes in bits 15:0), 0x20 (base low word), 0x24 (base high word) and 0x44 (bytes per channel). Control at 0x10 keeps only bit 0 (DMA enable), bit 13 (period interrupt enable), bit 14 (timeout interrupt enable), bits 18:16 (width code) and bits 22:19 (channel count); every other control bit reads 0. Unmapped offsets read 0.
- R3: The transfer count at 0x28 ignores writes. It rises by BEAT_BYTES on each beat where `beat_valid` and `beat_ready` are both 1. `beat_ready` is 1 only while control bit 0 is set and no soft reset is running.
- R4: When an accepted beat brings the count to period bytes × period count, the count becomes 0.
- R5: Status bit 31 becomes 1 on each beat that completes a period, including the one that wraps the ring. `irq` equals status bit 31 AND control bit 13.
- R6: Writing a one to status bit 31 clears it, and writing a zero there has no effect. If a period completes in the same cycle as the clearing write, the flag stays set.
- R7: A one on `chan_status_valid` sets status bit 29, and the bit stays set until a soft reset.
- R8: Writing control with bit 1 set starts a soft reset. Control bit 1 then reads 1 for RST_CYCLES cycles and drops by itself. The soft reset clears the count and both status flags at once and clears DMA enable. The other control fields and all other registers keep their values. Control writes made while the reset runs are ignored.
- R9: `buf_addr` equals {high word, low word} of the base address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |
| beat_valid | input | 1 | Transfer beat offered |
| beat_ready | output | 1 | Block accepts a beat this cycle |
| chan_status_valid | input | 1 | Channel-status data has been captured |
| buf_addr | output | 64 | Ring-buffer base address |
| irq | output | 1 | Period-complete interrupt |

## Verification
A wrong count or period offset shows in the value read at 0x28 right after the next accepted beat. It also shows in status bit 31 and `irq`, which must change in the same cycle as the beat that completes a period, and not on the beats before it. A broken reset sequencer shows in the width of the window during which control bit 1 reads 1, which the bench samples just before and just after its last cycle. A wrong clear priority shows as a missing flag when a clearing write coincides with a period end.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h14;
  localparam logic [7:0] OFS_RING   = 8'h1C;
  localparam logic [7:0] OFS_BASELO = 8'h20;
  localparam logic [7:0] OFS_BASEHI = 8'h24;
  localparam logic [7:0] OFS_COUNT  = 8'h28;
  localparam logic [7:0] OFS_BPC    = 8'h44;

  localparam int B_EN    = 0;
  localparam int B_SRST  = 1;
  localparam int B_PIE   = 13;
  localparam int B_TIE   = 14;
  localparam int B_WID   = 16;
  localparam int B_CHN   = 19;
  localparam int B_DONE  = 31;
  localparam int B_CSTAT = 29;

  // Size of the whole ring in bytes.
  function automatic logic [REG_W-1:0] ring_bytes(input logic [15:0] nper,
                                                  input logic [15:0] pbytes);
    return REG_W'(nper) * REG_W'(pbytes);
  endfunction

  // Byte position after one beat, before any wrap.
  function automatic logic [REG_W-1:0] advance(input logic [REG_W-1:0] pos,
                                               input int unsigned step);
    return pos + REG_W'(step);
  endfunction
endpackage

// File: rtl/adma_rst_seq.sv
module adma_rst_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic clr
);
  localparam int TW = $clog2(RST_CYCLES + 1);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          left_q <= '0;
    else if (start)      left_q <= TW'(RST_CYCLES);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != 0);
  assign clr  = start | busy;
endmodule

// File: rtl/adma_xfer_count.sv
module adma_xfer_count
  import adma_pkg::*;
#(
  parameter int BEAT_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             clr,
  input  logic [15:0]      pbytes,
  input  logic [15:0]      nper,
  output logic [REG_W-1:0] count,
  output logic             period_hit,
  output logic             ring_wrap
);
  logic [REG_W-1:0] cnt_q, pos_q, ring, cnt_sum, pos_sum;

  always_comb begin
    ring       = ring_bytes(nper, pbytes);
    cnt_sum    = advance(cnt_q, BEAT_BYTES);
    pos_sum    = advance(pos_q, BEAT_BYTES);
    period_hit = fire && !clr && (pos_sum >= REG_W'(pbytes));
    ring_wrap  = fire && !clr && (cnt_sum >= ring);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      pos_q <= '0;
    end else if (fire) begin
      cnt_q <= ring_wrap ? '0 : cnt_sum;
      pos_q <= ring_wrap ? '0 : (period_hit ? pos_sum - REG_W'(pbytes) : pos_sum);
    end
  end

  assign count = cnt_q;

  p_count_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && ring != 0) |=> (cnt_q < $past(ring)));

  p_hold_without_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/adma_chan_regs.sv
module adma_chan_regs
  import adma_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BEAT_BYTES = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic              chan_status_valid,
  output logic [63:0]       buf_addr,
  output logic              irq
);
  logic              en_q, pie_q, tie_q;
  logic [2:0]        wid_q;
  logic [3:0]        chn_q;
  logic [15:0]       nper_q, pbytes_q;
  logic [REG_W-1:0]  base_lo_q, base_hi_q, bpc_q;
  logic              done_q, cstat_q;

  logic              rst_busy, clr, srst_start, beat_fire;
  logic              period_hit, ring_wrap;
  logic [REG_W-1:0]  xfer_count;

  wire wr_ctrl = reg_we && (reg_addr == ADDR_W'(OFS_CTRL)) && !rst_busy;
  wire wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
  wire clr_done = wr_stat && reg_wdata[B_DONE];

  assign srst_start = wr_ctrl && reg_wdata[B_SRST];
  assign beat_ready = en_q && !rst_busy;
  assign beat_fire  = beat_valid && beat_ready;

  adma_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(rst_busy), .clr(clr)
  );

  adma_xfer_count #(.BEAT_BYTES(BEAT_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fire(beat_fire), .clr(clr),
    .pbytes(pbytes_q), .nper(nper_q), .count(xfer_count),
    .period_hit(period_hit), .ring_wrap(ring_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; pie_q <= 1'b0; tie_q <= 1'b0;
      wid_q <= '0; chn_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= reg_wdata[B_EN] && !reg_wdata[B_SRST];
      pie_q <= reg_wdata[B_PIE];
      tie_q <= reg_wdata[B_TIE];
      wid_q <= reg_wdata[B_WID +: 3];
      chn_q <= reg_wdata[B_CHN +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nper_q <= '0; pbytes_q <= '0;
      base_lo_q <= '0; base_hi_q <= '0; bpc_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_W'(OFS_RING):   {nper_q, pbytes_q} <= reg_wdata;
        ADDR_W'(OFS_BASELO): base_lo_q <= reg_wdata;
        ADDR_W'(OFS_BASEHI): base_hi_q <= reg_wdata;
        ADDR_W'(OFS_BPC):    bpc_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Flags: a completing period wins over a same-cycle clearing write.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      done_q  <= 1'b0;
      cstat_q <= 1'b0;
    end else begin
      if (period_hit)    done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (chan_status_valid) cstat_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_CTRL): begin
        reg_rdata[B_EN]       = en_q;
        reg_rdata[B_SRST]     = rst_busy;
        reg_rdata[B_PIE]      = pie_q;
        reg_rdata[B_TIE]      = tie_q;
        reg_rdata[B_WID +: 3] = wid_q;
        reg_rdata[B_CHN +: 4] = chn_q;
      end
      ADDR_W'(OFS_STAT): begin
        reg_rdata[B_DONE]  = done_q;
        reg_rdata[B_CSTAT] = cstat_q;
      end
      ADDR_W'(OFS_RING):   reg_rdata = {nper_q, pbytes_q};
      ADDR_W'(OFS_BASELO): reg_rdata = base_lo_q;
      ADDR_W'(OFS_BASEHI): reg_rdata = base_hi_q;
      ADDR_W'(OFS_COUNT):  reg_rdata = xfer_count;
      ADDR_W'(OFS_BPC):    reg_rdata = bpc_q;
      default: reg_rdata = '0;
    endcase
  end

  assign buf_addr = {base_hi_q, base_lo_q};
  assign irq      = done_q && pie_q;

  p_hit_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> done_q);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !period_hit) |=> !done_q);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (xfer_count == 0 && !beat_ready && !done_q && !cstat_q));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_wrap |=> (xfer_count == 0));
endmodule

// File: tb/sim_adma_chan_regs.sv
module sim_adma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        beat_valid = 1'b0;
  logic        beat_ready;
  logic        chan_status_valid = 1'b0;
  logic [63:0] buf_addr;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adma_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .chan_status_valid(chan_status_valid),
    .buf_addr(buf_addr), .irq(irq)
  );

  // {offset, write value, expected read}
  localparam logic [71:0] VEC [8] = '{
    {8'h10, 32'hF0136F00, 32'h00136000},
    {8'h1C, 32'h00060040, 32'h00060040},
    {8'h20, 32'hDEADBEEF, 32'hDEADBEEF},
    {8'h24, 32'h12345678, 32'h12345678},
    {8'h44, 32'h00000020, 32'h00000020},
    {8'h28, 32'h00001234, 32'h00000000},
    {8'h14, 32'hFFFFFFFF, 32'h00000000},
    {8'h30, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_valid = 1'b1;
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][71:64], v);
      check("R1 reset read", 64'(v), 64'h0);
    end
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 beat_ready", 64'(beat_ready), 64'h0);
    check("R1 buf_addr", buf_addr, 64'h0);

    // R2: table of writes and readbacks (R3: count ignores writes)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check("R2 readback", 64'(v), 64'(VEC[i][31:0]));
    end
    check("R9 buf_addr", buf_addr, 64'h12345678DEADBEEF);

    // Ring: 2 periods of 64 bytes, 8-byte beats
    wr(8'h1C, 32'h00020040);
    wr(8'h10, 32'h00002001);
    check("R3 beat_ready on", 64'(beat_ready), 64'h1);
    beats(7);
    rd(8'h28, v); check("R3 count after 7", 64'(v), 64'd56);
    rd(8'h14, v); check("R5 no flag mid period", 64'(v), 64'h0);
    check("R5 irq low mid period", 64'(irq), 64'h0);

    // R6: period end coincides with clearing write: flag stays
    beat_valid = 1'b1; reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h80000000;
    @(negedge clk);
    beat_valid = 1'b0; reg_we = 1'b0;
    rd(8'h14, v); check("R6 set wins", 64'(v), 64'h80000000);
    check("R5 irq on boundary", 64'(irq), 64'h1);
    rd(8'h28, v); check("R3 count 64", 64'(v), 64'd64);
    wr(8'h14, 32'h80000000);
    rd(8'h14, v); check("R6 w1c", 64'(v), 64'h0);
    check("R6 irq cleared", 64'(irq), 64'h0);

    beats(8);
    rd(8'h28, v); check("R4 wrap to zero", 64'(v), 64'h0);
    rd(8'h14, v); check("R5 flag on wrap", 64'(v), 64'h80000000);
    wr(8'h14, 32'h7FFFFFFF);
    rd(8'h14, v); check("R6 write zero no effect", 64'(v), 64'h80000000);
    wr(8'h10, 32'h00000001);
    check("R5 irq gated by enable", 64'(irq), 64'h0);

    beats(3);
    rd(8'h28, v); check("R3 count 24", 64'(v), 64'd24);
    wr(8'h10, 32'h00002000);
    check("R3 beat_ready off", 64'(beat_ready), 64'h0);
    beats(2);
    rd(8'h28, v); check("R3 no advance when disabled", 64'(v), 64'd24);

    // R7
    chan_status_valid = 1'b1; @(negedge clk); chan_status_valid = 1'b0;
    rd(8'h14, v); check("R7 chan status flag", 64'(v), 64'hA0000000);
    @(negedge clk);
    rd(8'h14, v); check("R7 sticky", 64'(v), 64'hA0000000);

    // R8: soft reset
    wr(8'h10, 32'h00002001);
    beats(1);
    wr(8'h10, 32'h00002003);
    rd(8'h10, v); check("R8 reset bit set, enable cleared", 64'(v), 64'h00002002);
    rd(8'h28, v); check("R8 count cleared", 64'(v), 64'h0);
    rd(8'h14, v); check("R8 flags cleared", 64'(v), 64'h0);
    check("R8 beat_ready low", 64'(beat_ready), 64'h0);
    wr(8'h10, 32'h00000001);
    rd(8'h10, v); check("R8 write ignored in reset", 64'(v), 64'h00002002);
    @(negedge clk); @(negedge clk);
    rd(8'h10, v); check("R8 still in reset", 64'(v), 64'h00002002);
    @(negedge clk);
    rd(8'h10, v); check("R8 reset bit dropped", 64'(v), 64'h00002000);
    rd(8'h1C, v); check("R8 ring kept", 64'(v), 64'h00020040);
    rd(8'h20, v); check("R8 base kept", 64'(v), 64'hDEADBEEF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule